// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synchronous static memory for simulation-scale arrays. Each word is 36 bits wide and is split into four 9-bit byte lanes. A lane holds 8 data bits and 1 parity bit. All addresses, enables, write controls and write data are captured on the rising clock edge. The access then takes place in the following cycle. A read result lands in an output register, and a write completes internally with no handshake.

An access begins with one of two address strobes. The processor strobe always starts a read and is honoured only while enable 1 is low. The controller strobe is not gated by enable 1, and it may start either a read or a write. Once an access has started, a 2-bit burst counter produces the later addresses of the burst, in interleaved or linear order. The counter steps when the advance input is low and holds when it is high.

The output enable works without the clock. When it is inactive, the read bus shows all zeros and a separate drive flag falls, which marks the bus as undriven. A sleep input blocks new accesses.

Top module: `sbsram_core`

## Requirements
- R1: After reset the output register is zero and no burst is active, so with `oe_n` low `rdata` reads 0 and `rdata_drv` is 1.
- R2: A read started by a strobe sampled at edge k shows its word on `rdata` after edge k+1. Each advance sampled at a later edge gives the next burst word one edge later, so the access rate is 3-1-1-1.
- R3: A write with `gwr_n` low stores all four lanes, whatever `bwe_n` and `bsel_n` are.
- R4: A write with `gwr_n` high and `bwe_n` low stores only the lanes whose `bsel_n[i]` is low. Lane i is bits 9i+8..9i: data in bits 9i+7..9i and parity in bit 9i+8. With both `gwr_n` and `bwe_n` high, no lane is written.
- R5: A strobe starts an access only when `en1_n`=0, `en2`=1 and `en3_n`=0. A strobe sampled while not selected ends the burst, and later advances perform no access, so the output holds.
- R6: The processor strobe is ignored while `en1_n` is high, and the burst goes on as directed by `adv_n`. The controller strobe with `en1_n` high deselects the block.
- R7: An access started by the processor strobe is a read, and the write controls in that cycle are ignored. An access started by the controller strobe follows the write controls.
- R8: A write cycle leaves the output register at its previous value.
- R9: A read issued in the cycle right after a write to the same address returns the newly written word.
- R10: The burst address keeps the upper address bits. Its low two bits are start XOR beat when `mode_lin`=0, and start + beat modulo 4 when `mode_lin`=1. The beat count wraps after four beats.
- R11: While a burst is active, with no strobe and `adv_n` high, the access repeats at the same address.
- R12: While `sleep` is high, no strobe starts an access (read or write) and the active burst is cleared.
- R13: With `oe_n` high, `rdata` is all zeros and `rdata_drv` is 0. With `oe_n` low, `rdata` shows the output register and `rdata_drv` is 1. Both follow `oe_n` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_lin | input | 1 | Burst order: 1 linear, 0 interleaved; captured at start |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane write select, active low |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request; blocks new accesses |
| rdata | output | 36 | Read data from the output register, zero when not driven |
| rdata_drv | output | 1 | High when the read bus is driven |

## Verification
Single accesses go through a table of write-control patterns: global write alone, global write with byte selects that disagree, single lanes including the parity-carrying top lane, scattered lanes, and byte enable withheld. Each write is followed by a read, which separates the global override from byte gating. Bursts starting at an odd offset are read in both orders and past the wrap; the two orders give different sequences from that start, so a swapped order or a missing wrap shows. Directed sequences then change one control at a time against an active burst: a suspended advance, a deselecting strobe, a processor strobe with enable 1 high, a controller strobe with enable 1 high, sleep, and a write carried on a processor strobe. In each of these a wrong design leaves a different word in the output register than a correct one.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;

  // Low two address bits for a given beat of a burst.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       linear);
    logic [1:0] sum;
    sum = start + beat;
    return linear ? sum : (start ^ beat);
  endfunction

  // Lanes written by one cycle's write controls (global write wins).
  function automatic lane_mask_t write_lanes(input logic       gw_n,
                                             input logic       be_n,
                                             input lane_mask_t sel_n);
    if (!gw_n)      return '1;
    else if (!be_n) return ~sel_n;
    else            return '0;
  endfunction
endpackage

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          load_lin,
  input  logic          step,
  output logic [AW-1:0] acc_addr,
  output logic [1:0]    beat
);
  import sbsram_pkg::*;

  logic [AW-1:0] base_q;
  logic          lin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat   <= '0;
      lin_q  <= 1'b0;
    end else if (load) begin
      base_q <= load_addr;
      beat   <= '0;
      lin_q  <= load_lin;
    end else if (step) begin
      beat   <= beat + 2'd1;
    end
  end

  assign acc_addr = {base_q[AW-1:2], burst_low(base_q[1:0], beat, lin_q)};
endmodule

// File: rtl/sbsram_access_ctl.sv
module sbsram_access_ctl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en1_n,
  input  logic                   en2,
  input  logic                   en3_n,
  input  logic                   strobe_p_n,
  input  logic                   strobe_c_n,
  input  logic                   adv_n,
  input  logic                   sleep,
  input  logic                   gwr_n,
  input  logic                   bwe_n,
  input  sbsram_pkg::lane_mask_t bsel_n,
  output logic                   ev_start,
  output logic                   ev_desel,
  output logic                   ev_step,
  output logic                   active_q,
  output logic                   acc_q,
  output sbsram_pkg::lane_mask_t wr_q
);
  import sbsram_pkg::*;

  logic       p_seen, c_seen, strobe_any, selected, cont, acc_d, active_d;
  lane_mask_t wr_d;

  assign p_seen     = !strobe_p_n && !en1_n;
  assign c_seen     = !strobe_c_n;
  assign strobe_any = !sleep && (p_seen || c_seen);
  assign selected   = !en1_n && en2 && !en3_n;
  assign ev_start   = strobe_any && selected;
  assign ev_desel   = strobe_any && !selected;
  assign cont       = !sleep && !strobe_any && active_q;
  assign ev_step    = cont && !adv_n;
  assign acc_d      = ev_start || cont;

  always_comb begin
    if (!acc_d || (ev_start && p_seen)) wr_d = '0;
    else                                wr_d = write_lanes(gwr_n, bwe_n, bsel_n);
  end

  always_comb begin
    if (ev_start)               active_d = 1'b1;
    else if (sleep || ev_desel) active_d = 1'b0;
    else                        active_d = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      acc_q    <= 1'b0;
      wr_q     <= '0;
    end else begin
      active_q <= active_d;
      acc_q    <= acc_d;
      wr_q     <= wr_d;
    end
  end
endmodule

// File: rtl/sbsram_lane_array.sv
module sbsram_lane_array #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic                   clk,
  input  logic [AW-1:0]          addr,
  input  sbsram_pkg::lane_mask_t we,
  input  sbsram_pkg::word_t      wd,
  output sbsram_pkg::word_t      rd
);
  import sbsram_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wd[g*LANE_W +: LANE_W];
    end

    assign rd[g*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  input  logic          strobe_p_n,
  input  logic          strobe_c_n,
  input  logic          adv_n,
  input  logic          mode_lin,
  input  logic          gwr_n,
  input  logic          bwe_n,
  input  logic [3:0]    bsel_n,
  input  logic [35:0]   wdata,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [35:0]   rdata,
  output logic          rdata_drv
);
  import sbsram_pkg::*;

  logic          ev_start, ev_desel, ev_step, active_q, acc_q;
  logic          ev_read, ev_write;
  lane_mask_t    wr_q, arr_we;
  logic [AW-1:0] acc_addr;
  logic [1:0]    beat;
  word_t         wdata_q, arr_rd, out_q;

  sbsram_access_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .sleep(sleep), .gwr_n(gwr_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .ev_start(ev_start), .ev_desel(ev_desel), .ev_step(ev_step),
    .active_q(active_q), .acc_q(acc_q), .wr_q(wr_q)
  );

  sbsram_burst_ctr #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .load_addr(addr),
    .load_lin(mode_lin), .step(ev_step), .acc_addr(acc_addr), .beat(beat)
  );

  assign ev_write = acc_q && (wr_q != '0);
  assign ev_read  = acc_q && (wr_q == '0);
  assign arr_we   = ev_write ? wr_q : '0;

  sbsram_lane_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .addr(acc_addr), .we(arr_we), .wd(wdata_q), .rd(arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      out_q   <= '0;
    end else begin
      wdata_q <= wdata;
      if (ev_read) out_q <= arr_rd;
    end
  end

  assign rdata     = oe_n ? '0 : out_q;
  assign rdata_drv = !oe_n;
endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en1_n,
  input logic          en2,
  input logic          en3_n,
  input logic          strobe_p_n,
  input logic          strobe_c_n,
  input logic          adv_n,
  input logic          gwr_n,
  input logic          sleep,
  input logic          ev_start,
  input logic          ev_desel,
  input logic          ev_step,
  input logic          active_q,
  input logic          acc_q,
  input logic [3:0]    wr_q,
  input logic [1:0]    beat,
  input logic [AW-1:0] acc_addr,
  input logic [35:0]   out_q
);
  p_gw_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe_c_n && strobe_p_n && !en1_n && en2 && !en3_n && !gwr_n)
      |=> (wr_q == 4'hF));

  p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> !acc_q && !active_q);

  p_pstrobe_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p_n && en1_n && strobe_c_n) |-> (!ev_start && !ev_desel));

  p_pstart_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !strobe_p_n && !en1_n) |=> (acc_q && wr_q == 4'h0));

  p_write_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && wr_q != 4'h0) |=> $stable(out_q));

  p_beat_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (beat == $past(beat) + 2'd1));

  p_suspend_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe_p_n && strobe_c_n && adv_n && active_q) |=> $stable(acc_addr));

  p_sleep_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!acc_q && !active_q));
endmodule

bind sbsram_core sbsram_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
  .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
  .gwr_n(gwr_n), .sleep(sleep), .ev_start(ev_start), .ev_desel(ev_desel),
  .ev_step(ev_step), .active_q(active_q), .acc_q(acc_q), .wr_q(wr_q),
  .beat(beat), .acc_addr(acc_addr), .out_q(out_q)
);

// File: tb/sbsram_core_test.sv
module sbsram_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  typedef struct packed {
    logic [7:0]  a;
    logic        gw_n;
    logic        be_n;
    logic [3:0]  sel_n;
    logic [35:0] d;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{8'h40, 1'b0, 1'b1, 4'hF, 36'h9_1357_9BDF},  // R3 global alone
    '{8'h40, 1'b0, 1'b0, 4'hA, 36'h2_4680_ACE1},  // R3 global overrides selects
    '{8'h41, 1'b0, 1'b1, 4'h0, 36'h7_0F0F_0F0F},  // R3
    '{8'h41, 1'b1, 1'b0, 4'hE, 36'h0_0000_01FF},  // R4 lane 0
    '{8'h41, 1'b1, 1'b0, 4'h5, 36'hF_FFFF_FFFF},  // R4 lanes 1 and 3
    '{8'h42, 1'b1, 1'b1, 4'h0, 36'hC_3C3C_3C3C},  // R4 byte enable withheld
    '{8'h42, 1'b1, 1'b0, 4'h7, 36'hF_F000_0000},  // R4 lane 3 with parity
    '{8'h40, 1'b1, 1'b0, 4'h0, 36'h5_A5A5_A5A5}   // R4 all lanes by selects
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] addr;
  logic        en1_n, en2, en3_n, strobe_p_n, strobe_c_n, adv_n, mode_lin;
  logic        gwr_n, bwe_n, oe_n, sleep;
  logic [3:0]  bsel_n;
  logic [35:0] wdata, rdata;
  logic        rdata_drv;

  logic [35:0] model [0:255];
  int tests = 0;
  int fails = 0;

  sbsram_core #(.DEPTH(256)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en1_n(en1_n), .en2(en2),
    .en3_n(en3_n), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .adv_n(adv_n), .mode_lin(mode_lin), .gwr_n(gwr_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    strobe_p_n = 1'b1; strobe_c_n = 1'b1; adv_n = 1'b1;
    gwr_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
    en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0; sleep = 1'b0;
  endtask

  // Controller-strobe write, access done one edge later; model updated here.
  task automatic do_write(input logic [7:0] a, input logic gw, input logic be,
                          input logic [3:0] sel, input logic [35:0] d);
    idle();
    strobe_c_n = 1'b0; addr = a; gwr_n = gw; bwe_n = be; bsel_n = sel; wdata = d;
    for (int j = 0; j < 4; j++)
      if (!gw || (!be && !sel[j])) model[a][j*9 +: 9] = d[j*9 +: 9];
    cyc();
    idle();
    cyc();
  endtask

  task automatic do_read(input logic [7:0] a);
    idle();
    strobe_p_n = 1'b0; addr = a;
    cyc();
    idle();
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    addr = '0; wdata = '0; mode_lin = 1'b0; oe_n = 1'b0; rst_n = 1'b0;
    repeat (3) cyc();
    // R1 reset state
    check("R1 rdata", rdata, 36'h0);
    check("R1 drv", {35'h0, rdata_drv}, 36'h1);
    rst_n = 1'b1;
    cyc();

    // Initialise the lines the table touches
    for (int i = 0; i < 3; i++) do_write(8'h40 + 8'(i), 1'b0, 1'b1, 4'hF, 36'h1_1111_1111 * (i + 1));

    // R3/R4 table walk
    foreach (VECS[i]) begin
      do_write(VECS[i].a, VECS[i].gw_n, VECS[i].be_n, VECS[i].sel_n, VECS[i].d);
      do_read(VECS[i].a);
      check((!VECS[i].gw_n) ? "R3 global write" : "R4 byte write", rdata, model[VECS[i].a]);
    end

    // R12 sleep: deselect first, then strobes under sleep
    begin
      logic [35:0] h;
      idle(); strobe_c_n = 1'b0; en2 = 1'b0; cyc();
      idle(); cyc();
      h = rdata;
      idle(); sleep = 1'b1; strobe_p_n = 1'b0; addr = 8'h41; cyc();
      idle(); adv_n = 1'b0; cyc(); cyc();
      check("R12 sleep read blocked", rdata, h);
      idle(); sleep = 1'b1; strobe_c_n = 1'b0; gwr_n = 1'b0; addr = 8'h42; wdata = 36'hB_AD0B_AD0B; cyc();
      idle(); cyc();
      do_read(8'h42);
      check("R12 sleep write blocked", rdata, model[8'h42]);
    end

    // Burst lines 0x50..0x53
    for (int i = 0; i < 4; i++) do_write(8'h50 + 8'(i), 1'b0, 1'b1, 4'hF, 36'hE_0000_0000 + 36'(i * 36'h1_0101));

    // R2/R10 bursts from offset 1 in both orders, past the wrap
    for (int m = 0; m < 2; m++) begin
      idle(); mode_lin = m[0]; strobe_p_n = 1'b0; addr = 8'h51; cyc();
      idle(); adv_n = 1'b0;
      for (int b = 0; b < 5; b++) begin
        logic [1:0] lo;
        lo = m[0] ? 2'(1 + b) : (2'd1 ^ 2'(b));
        cyc();
        check(m[0] ? "R10 linear beat (R2 timing)" : "R10 interleaved beat (R2 timing)",
              rdata, model[{6'b010100, lo}]);
      end
    end
    mode_lin = 1'b0;

    // R11 suspended burst
    idle(); strobe_p_n = 1'b0; addr = 8'h51; cyc();
    idle(); cyc(); cyc();
    check("R11 suspend repeats", rdata, model[8'h51]);
    adv_n = 1'b0; cyc(); cyc();
    check("R11 resume next beat", rdata, model[8'h50]);

    // R5 deselecting strobe stops the burst
    begin
      logic [35:0] h;
      idle(); adv_n = 1'b0; strobe_c_n = 1'b0; en2 = 1'b0; cyc();
      h = rdata;
      idle(); adv_n = 1'b0; cyc(); cyc();
      check("R5 deselect holds", rdata, h);
    end

    // R6 processor strobe ignored with en1_n high; controller strobe not
    idle(); strobe_p_n = 1'b0; addr = 8'h50; cyc();
    idle(); strobe_p_n = 1'b0; en1_n = 1'b1; adv_n = 1'b0; addr = 8'h53; cyc();
    idle(); cyc();
    check("R6 proc strobe ignored", rdata, model[8'h51]);
    idle(); strobe_c_n = 1'b0; en1_n = 1'b1; adv_n = 1'b0; cyc();
    idle(); adv_n = 1'b0; cyc();
    check("R6 ctrl strobe deselects", rdata, model[8'h51]);

    // R7 processor-strobe start ignores write controls
    idle(); strobe_p_n = 1'b0; addr = 8'h42; gwr_n = 1'b0; wdata = 36'h0_DEAD_BEEF; cyc();
    idle(); cyc();
    check("R7 proc start reads", rdata, model[8'h42]);
    do_read(8'h42);
    check("R7 memory unchanged", rdata, model[8'h42]);

    // R8 write leaves output register
    do_read(8'h40);
    idle(); strobe_c_n = 1'b0; addr = 8'h41; gwr_n = 1'b0; wdata = 36'h3_3333_CCCC;
    model[8'h41] = 36'h3_3333_CCCC;
    cyc();
    idle(); cyc();
    check("R8 write holds output", rdata, model[8'h40]);

    // R9 pass-through read right after a write
    idle(); strobe_c_n = 1'b0; addr = 8'h42; gwr_n = 1'b0; wdata = 36'h6_7890_1234;
    model[8'h42] = 36'h6_7890_1234;
    cyc();
    idle(); strobe_p_n = 1'b0; addr = 8'h42; cyc();
    idle(); cyc();
    check("R9 pass-through", rdata, model[8'h42]);

    // R13 asynchronous output enable
    oe_n = 1'b1; #1;
    check("R13 bus off data", rdata, 36'h0);
    check("R13 bus off flag", {35'h0, rdata_drv}, 36'h0);
    oe_n = 1'b0; #1;
    check("R13 bus on data", rdata, model[8'h42]);
    check("R13 bus on flag", {35'h0, rdata_drv}, 36'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule